// File: doc/BRIEF.md
# Predicated Vector Element Issue Compactor

This block takes a single vectorised operation and breaks it into groups of scalar element operations for an ALU that has a fixed number of lanes. The operation carries a vector length, a predicate mask with one bit per element, an invert flag and a zeroing flag. Every issue cycle the block finds the lowest-numbered elements that are still pending. It packs them into consecutive ALU lanes starting at lane 0 and removes them from the pending set. The reduced operation is held and presented again on the next cycle until nothing is left.

Elements whose predicate is off use no lane when zeroing is off. When zeroing is on, every element below the vector length is issued, and the inactive ones are flagged so that the datapath writes zero to them. Each lane reports the element index and the destination and source register numbers for that element, formed as base plus element index. A new operation is taken through a valid/ready handshake only after the previous one has issued its final group.

Top module: `vcmp_issue`

## Requirements
- R1: After reset, `iss_valid`, `iss_zero` and `iss_last` are all zero and `op_ready` is high.
- R2: Issued elements fill lanes from lane 0 upward with no gaps (`iss_valid` is a run of ones from bit 0). Lane indices increase with the lane number, and the lowest pending elements are always issued first.
- R3: An operation with k pending elements takes max(1, ceil(k/LANES)) issue cycles, the first one registered at the clock edge after acceptance. Every group except the last fills all lanes. For example, six enabled elements out of eight on a 4-lane ALU issue as 4 and then 2.
- R4: Elements at or above the vector length are never issued. A length greater than XLEN acts as XLEN.
- R5: When the invert flag is set, an element is active when its mask bit is 0.
- R6: With zeroing on, every element below the vector length is issued in ascending order. `iss_zero` is 1 exactly on lanes whose element is inactive, and `iss_zero` is never set on an invalid lane.
- R7: An operation with no pending element issues one cycle with no valid lane and `iss_last` high. When no operation is issuing, all lane outputs are zero.
- R8: `iss_last` is high exactly on the cycle that carries an operation's final group, and `op_ready` is high in that same cycle.
- R9: `op_ready` goes low at the edge that accepts an operation and stays low until the final group is issued. `op_valid` while `op_ready` is low has no effect.
- R10: On each valid lane, `iss_rd`, `iss_rs1` and `iss_rs2` equal the corresponding base register plus the element index, modulo 2^REG_W. Invalid lanes carry zero in the index and register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block can accept an operation |
| op_rd | input | REG_W | Destination base register |
| op_rs1 | input | REG_W | First source base register |
| op_rs2 | input | REG_W | Second source base register |
| op_vl | input | clog2(XLEN+1) | Vector length |
| op_mask | input | XLEN | Predicate, bit e for element e |
| op_inv | input | 1 | Complement the predicate |
| op_zero | input | 1 | Issue inactive elements as zero writes |
| iss_valid | output | LANES | Per-lane valid |
| iss_zero | output | LANES | Per-lane zero-write flag |
| iss_idx | output | LANES*clog2(XLEN) | Per-lane element index, lane 0 in the low bits |
| iss_rd | output | LANES*REG_W | Per-lane destination register |
| iss_rs1 | output | LANES*REG_W | Per-lane first source register |
| iss_rs2 | output | LANES*REG_W | Per-lane second source register |
| iss_last | output | 1 | Final group of the operation |

## Verification
Two things can happen in the same cycle: the final group is issued, and the block becomes free for the next operation. A stray request may also arrive while the residual is still being drained. The bench holds `op_valid` high with unrelated operands during the busy cycles. It then checks that every group still matches the model of the original operation, that `op_ready` rises only together with `iss_last`, and that the next real operation starts cleanly after that. Random masks, lengths, invert and zeroing settings, including empty and full-length cases, are compared group by group with a bench model of the ascending pending list.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int MAX_XLEN = 64;

  // thermometer test: a run of ones from bit 0, or all zero
  function automatic logic is_packed(input logic [MAX_XLEN-1:0] v);
    return ((v + 1'b1) & v) == '0;
  endfunction
endpackage

// File: rtl/vcmp_ffs.sv
module vcmp_ffs #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vcmp_select.sv
module vcmp_select #(
  parameter int W     = 32,
  parameter int IW    = 5,
  parameter int LANES = 4
) (
  input  logic [W-1:0]        resid,
  output logic [LANES-1:0]    lane_vld,
  output logic [LANES*IW-1:0] lane_idx,
  output logic [W-1:0]        rest
);
  logic [LANES:0][W-1:0] chain;

  assign chain[0] = resid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vcmp_ffs #(.W(W), .IW(IW)) u_ffs (
      .mask  (chain[l]),
      .found (lane_vld[l]),
      .idx   (lane_idx[l*IW +: IW])
    );
    assign chain[l+1] = chain[l] &
      ~(lane_vld[l] ? (W'(1) << lane_idx[l*IW +: IW]) : W'(0));
  end

  assign rest = chain[LANES];
endmodule

// File: rtl/vcmp_issue.sv
module vcmp_issue #(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int IDXW = $clog2(XLEN),
  localparam int VLW  = $clog2(XLEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [REG_W-1:0]       op_rd,
  input  logic [REG_W-1:0]       op_rs1,
  input  logic [REG_W-1:0]       op_rs2,
  input  logic [VLW-1:0]         op_vl,
  input  logic [XLEN-1:0]        op_mask,
  input  logic                   op_inv,
  input  logic                   op_zero,
  output logic [LANES-1:0]       iss_valid,
  output logic [LANES-1:0]       iss_zero,
  output logic [LANES*IDXW-1:0]  iss_idx,
  output logic [LANES*REG_W-1:0] iss_rd,
  output logic [LANES*REG_W-1:0] iss_rs1,
  output logic [LANES*REG_W-1:0] iss_rs2,
  output logic                   iss_last
);
  logic             busy;
  logic [XLEN-1:0]  resid;
  logic [XLEN-1:0]  act;
  logic [REG_W-1:0] b_rd, b_rs1, b_rs2;

  // operand decode at acceptance
  logic [XLEN-1:0]  lim, pred, seed;

  always_comb begin
    if (op_vl >= VLW'(XLEN)) lim = '1;
    else                     lim = (XLEN'(1) << op_vl) - XLEN'(1);
    pred = (op_mask ^ {XLEN{op_inv}}) & lim;
    seed = op_zero ? lim : pred;
  end

  // lane selection on the residual
  logic [LANES-1:0]      lane_vld;
  logic [LANES*IDXW-1:0] lane_idx;
  logic [XLEN-1:0]       rest;

  vcmp_select #(.W(XLEN), .IW(IDXW), .LANES(LANES)) u_sel (
    .resid    (resid),
    .lane_vld (lane_vld),
    .lane_idx (lane_idx),
    .rest     (rest)
  );

  logic [LANES-1:0]       n_zero;
  logic [LANES*IDXW-1:0]  n_idx;
  logic [LANES*REG_W-1:0] n_rd, n_rs1, n_rs2;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      n_idx[l*IDXW +: IDXW]   = lane_vld[l] ? lane_idx[l*IDXW +: IDXW] : '0;
      n_zero[l]               = lane_vld[l] & ~act[lane_idx[l*IDXW +: IDXW]];
      n_rd[l*REG_W +: REG_W]  = lane_vld[l] ? b_rd  + REG_W'(lane_idx[l*IDXW +: IDXW]) : '0;
      n_rs1[l*REG_W +: REG_W] = lane_vld[l] ? b_rs1 + REG_W'(lane_idx[l*IDXW +: IDXW]) : '0;
      n_rs2[l*REG_W +: REG_W] = lane_vld[l] ? b_rs2 + REG_W'(lane_idx[l*IDXW +: IDXW]) : '0;
    end
  end

  assign op_ready = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      resid     <= '0;
      act       <= '0;
      b_rd      <= '0;
      b_rs1     <= '0;
      b_rs2     <= '0;
      iss_valid <= '0;
      iss_zero  <= '0;
      iss_idx   <= '0;
      iss_rd    <= '0;
      iss_rs1   <= '0;
      iss_rs2   <= '0;
      iss_last  <= 1'b0;
    end else if (!busy) begin
      iss_valid <= '0;
      iss_zero  <= '0;
      iss_idx   <= '0;
      iss_rd    <= '0;
      iss_rs1   <= '0;
      iss_rs2   <= '0;
      iss_last  <= 1'b0;
      if (op_valid) begin
        busy  <= 1'b1;
        resid <= seed;
        act   <= pred;
        b_rd  <= op_rd;
        b_rs1 <= op_rs1;
        b_rs2 <= op_rs2;
      end
    end else begin
      resid     <= rest;
      iss_valid <= lane_vld;
      iss_zero  <= n_zero;
      iss_idx   <= n_idx;
      iss_rd    <= n_rd;
      iss_rs1   <= n_rs1;
      iss_rs2   <= n_rs2;
      iss_last  <= (rest == '0);
      if (rest == '0) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/vcmp_issue_chk.sv
module vcmp_issue_chk #(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int IDXW = $clog2(XLEN)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  op_valid,
  input logic                  op_ready,
  input logic [LANES-1:0]      iss_valid,
  input logic [LANES-1:0]      iss_zero,
  input logic [LANES*IDXW-1:0] iss_idx,
  input logic                  iss_last
);
  logic ord_ok;
  logic pack_ok;

  always_comb begin
    ord_ok = 1'b1;
    for (int l = 1; l < LANES; l++) begin
      if (iss_valid[l] &&
          iss_idx[l*IDXW +: IDXW] <= iss_idx[(l-1)*IDXW +: IDXW])
        ord_ok = 1'b0;
    end
    pack_ok = vcmp_pkg::is_packed(vcmp_pkg::MAX_XLEN'(iss_valid));
  end

  assert_lane_pack_R2: assert property (@(posedge clk) disable iff (rst)
    pack_ok);

  assert_ascending_R2: assert property (@(posedge clk) disable iff (rst)
    ord_ok);

  assert_full_group_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid != '0 && !iss_last) |-> (&iss_valid));

  assert_zero_in_lane_R6: assert property (@(posedge clk) disable iff (rst)
    (iss_zero & ~iss_valid) == '0);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (op_ready && !iss_last) |-> (iss_valid == '0));

  assert_done_frees_R8: assert property (@(posedge clk) disable iff (rst)
    iss_last |-> op_ready);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> !op_ready);
endmodule

bind vcmp_issue vcmp_issue_chk #(.XLEN(XLEN), .LANES(LANES), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_vcmp_issue.sv
module tb_vcmp_issue;
  localparam int XLEN = 32;
  localparam int L    = 4;
  localparam int RW   = 5;
  localparam int IW   = $clog2(XLEN);
  localparam int VW   = $clog2(XLEN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [RW-1:0] op_rd = '0, op_rs1 = '0, op_rs2 = '0;
  logic [VW-1:0] op_vl = '0;
  logic [XLEN-1:0] op_mask = '0;
  logic op_inv = 1'b0, op_zero = 1'b0;
  logic [L-1:0] iss_valid, iss_zero;
  logic [L*IW-1:0] iss_idx;
  logic [L*RW-1:0] iss_rd, iss_rs1, iss_rs2;
  logic iss_last;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vcmp_issue #(.XLEN(XLEN), .LANES(L), .REG_W(RW)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2), .op_vl(op_vl),
    .op_mask(op_mask), .op_inv(op_inv), .op_zero(op_zero),
    .iss_valid(iss_valid), .iss_zero(iss_zero), .iss_idx(iss_idx),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_last(iss_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one operation: model the ascending pending list, then compare each group
  task automatic run_op(input string tag, input logic [XLEN-1:0] mask, input int vl,
                        input bit inv, input bit zro, input logic [RW-1:0] rd,
                        input logic [RW-1:0] rs1, input logic [RW-1:0] rs2,
                        input bit noise);
    int e_idx[XLEN];
    bit e_z[XLEN];
    int n = 0;
    int groups;
    for (int e = 0; e < vl && e < XLEN; e++) begin
      bit p = mask[e] ^ inv;
      if (zro || p) begin
        e_idx[n] = e;
        e_z[n] = zro && !p;
        n++;
      end
    end
    groups = (n == 0) ? 1 : (n + L - 1) / L;

    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_mask = mask; op_vl = VW'(vl); op_inv = inv; op_zero = zro;
    op_rd = rd; op_rs1 = rs1; op_rs2 = rs2;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(!op_ready, "R9", "ready low after accept", 64'(op_ready), 64'(0));

    for (int g = 0; g < groups; g++) begin
      logic [L-1:0] xv, xz;
      logic [L*IW-1:0] xi;
      logic [L*RW-1:0] xrd, xr1, xr2;
      @(negedge clk);
      op_valid = 1'b0;
      xv = '0; xz = '0; xi = '0; xrd = '0; xr1 = '0; xr2 = '0;
      for (int l = 0; l < L; l++) begin
        int k = g * L + l;
        if (k < n) begin
          xv[l] = 1'b1;
          xz[l] = e_z[k];
          xi[l*IW +: IW]  = IW'(e_idx[k]);
          xrd[l*RW +: RW] = RW'(rd + RW'(e_idx[k]));
          xr1[l*RW +: RW] = RW'(rs1 + RW'(e_idx[k]));
          xr2[l*RW +: RW] = RW'(rs2 + RW'(e_idx[k]));
        end
      end
      chk(iss_valid == xv, tag, "lane valid (R2/R3)", 64'(iss_valid), 64'(xv));
      chk(iss_idx == xi, tag, "element index (R2/R4)", 64'(iss_idx), 64'(xi));
      chk(iss_zero == xz, tag, "zero flags (R6)", 64'(iss_zero), 64'(xz));
      chk({iss_rd, iss_rs1, iss_rs2} == {xrd, xr1, xr2}, tag, "registers (R10)",
          64'({iss_rd, iss_rs1, iss_rs2}), 64'({xrd, xr1, xr2}));
      chk(iss_last == (g == groups - 1), tag, "last flag (R8)",
          64'(iss_last), 64'(g == groups - 1));
      if (g < groups - 1) begin
        chk(!op_ready, "R9", "ready low while draining", 64'(op_ready), 64'(0));
        if (noise) begin
          // stray request while busy must not be taken
          op_valid = 1'b1; op_mask = $urandom; op_vl = VW'($urandom % 33);
          op_inv = 1'($urandom); op_zero = 1'($urandom);
          op_rd = RW'($urandom); op_rs1 = RW'($urandom); op_rs2 = RW'($urandom);
        end
      end
    end
    chk(op_ready, "R8", "ready high with final group", 64'(op_ready), 64'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(iss_valid == '0 && iss_zero == '0 && !iss_last, "R1", "outputs after reset",
        64'({iss_valid, iss_zero, iss_last}), 64'(0));
    chk(op_ready, "R1", "ready after reset", 64'(op_ready), 64'(1));

    run_op("R3", 32'h0000_00DB, 8, 0, 0, 5'd1, 5'd2, 5'd3, 0);
    run_op("R7", 32'h0000_0000, 16, 0, 0, 5'd4, 5'd5, 5'd6, 0);
    run_op("R7", 32'hFFFF_FFFF, 0, 0, 0, 5'd0, 5'd0, 5'd0, 0);
    run_op("R4", 32'hFFFF_FFFF, 5, 0, 0, 5'd8, 5'd9, 5'd10, 0);
    run_op("R4", 32'hFFFF_FFFF, 32, 0, 0, 5'd0, 5'd3, 5'd7, 0);
    run_op("R4", 32'h8000_0001, 45, 0, 0, 5'd2, 5'd2, 5'd2, 0);
    run_op("R5", 32'hFFFF_FF0F, 12, 1, 0, 5'd1, 5'd1, 5'd1, 0);
    run_op("R6", 32'h0000_00A5, 8, 0, 1, 5'd3, 5'd4, 5'd5, 0);
    run_op("R6", 32'h0000_00F0, 8, 1, 1, 5'd0, 5'd0, 5'd0, 0);
    run_op("R7", 32'h0000_0000, 0, 0, 1, 5'd0, 5'd0, 5'd0, 0);
    run_op("R10", 32'h0000_000F, 4, 0, 0, 5'd30, 5'd31, 5'd0, 0);
    run_op("R9", 32'hFFFF_FFFF, 20, 0, 0, 5'd6, 5'd7, 5'd8, 1);
    run_op("R9", 32'h0000_0003, 2, 0, 0, 5'd11, 5'd12, 5'd13, 1);

    for (int t = 0; t < 80; t++) begin
      run_op("R2", $urandom, int'($urandom % 34), 1'($urandom), 1'($urandom),
             RW'($urandom), RW'($urandom), RW'($urandom), 1'($urandom));
    end

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule